// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Rounding Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in several lanes at once. Each lane keeps the middle sixteen bits of its 24-bit product and rounds them with the bit just below. A variant select decides where each lane's pixel and coefficient come from in the two 64-bit operands, and how the lane results are packed into the 64-bit output word.

The four-lane variants are: pixels packed one per byte, a coefficient shared by all lanes and taken from either half of the low operand word, and pixels taken from the upper or the lower byte of each 16-bit field. Two further variants use only two lanes and place each result at an odd bit offset inside a 32-bit slot. A new operand pair is taken on every cycle with the input valid high. The packed result appears in an output register one clock later and stays there until the next valid input.

Top module: `pmul8x16_rnd`

## Requirements
- R1: Each lane forms the exact two's complement product of an unsigned 8-bit pixel and a signed 16-bit coefficient. It returns product bits [23:8] plus one when product bit 7 is set, and the sum wraps modulo 2^16 without saturation (pixel 1 times coefficient 0xFFFF gives 0x0000).
- R2: With select 0, lane i (0..3) multiplies op_a[8i+7:8i] by op_b[16i+15:16i]. Its result occupies result[16i+15:16i].
- R3: With select 1, every lane i multiplies op_a[8i+7:8i] by the shared coefficient op_b[31:16]. Results are packed as in R2.
- R4: With select 2, every lane i multiplies op_a[8i+7:8i] by the shared coefficient op_b[15:0]. Results are packed as in R2.
- R5: With select 3, lane i multiplies op_a[16i+15:16i+8] by op_b[16i+15:16i]. Results are packed as in R2.
- R6: With select 4, lane i multiplies op_a[16i+7:16i] by op_b[16i+15:16i]. Results are packed as in R2.
- R7: With select 5, only lanes 0 and 1 are active, with pixel op_a[16i+15:16i+8] and coefficient op_b[16i+15:16i]. Lane i's result sits at result[32i+22:32i+7] and every other result bit is zero.
- R8: With select 6, the placement is the same as R7, but the pixel of lane i is op_a[16i+7:16i].
- R9: Select 7 is reserved and yields an all-zero result word.
- R10: result and out_valid change at the first rising clock edge after in_valid is sampled high. out_valid is in_valid delayed by one cycle.
- R11: While in_valid is low, result keeps its last value, whatever the operands and select do.
- R12: While rst_n is low, result is zero and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| mode_sel | input | 3 | Operand-selection variant, codes 0 to 7 |
| op_a | input | 64 | Pixel operand |
| op_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | result holds a fresh product word |
| result | output | 64 | Packed, rounded lane results |

## Verification
Every variant is driven with operands that use distinct byte values in every field. A wrong lane-to-field mapping, or a swap of upper and lower bytes, therefore shows up as a different product. Coefficients cover zero, small positive values, the most negative value and negative values near minus one. Pixels cover zero, one and 255. Together these separate correct sign extension, the round-up on bit 7 and the 16-bit wraparound. The double-width variants are loaded with nonzero upper operand fields, to show that those fields are ignored and that the gap bits stay zero. The hold and reserved-code cases change the operands while in_valid is low, or while the select is 7, and the output is then observed directly.

// File: rtl/pmul8x16_pkg.sv
package pmul8x16_pkg;

   typedef enum logic [2:0] {
      PM_BASIC   = 3'd0,
      PM_COEF_HI = 3'd1,
      PM_COEF_LO = 3'd2,
      PM_BYTE_HI = 3'd3,
      PM_BYTE_LO = 3'd4,
      PM_WIDE_HI = 3'd5,
      PM_WIDE_LO = 3'd6,
      PM_NONE    = 3'd7
   } pm_mode_e;

endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
   import pmul8x16_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int LANES = 4
) (
   input  pm_mode_e                   mode,
   input  logic [LANES*2*PIX_W-1:0]   op_a,
   input  logic [LANES*2*PIX_W-1:0]   op_b,
   output logic [LANES-1:0][PIX_W-1:0]   pix,
   output logic [LANES-1:0][2*PIX_W-1:0] coef
);
   localparam int COEF_W = 2 * PIX_W;
   localparam int HALF   = LANES / 2;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [PIX_W-1:0]  pix_packed, pix_hi, pix_lo;
      logic [COEF_W-1:0] coef_own;

      assign pix_packed = op_a[i*PIX_W +: PIX_W];
      assign pix_hi     = op_a[i*COEF_W+PIX_W +: PIX_W];
      assign pix_lo     = op_a[i*COEF_W +: PIX_W];
      assign coef_own   = op_b[i*COEF_W +: COEF_W];

      if (i < HALF) begin : g_wide_capable
         always_comb begin
            pix[i]  = '0;
            coef[i] = '0;
            unique case (mode)
               PM_BASIC:   begin pix[i] = pix_packed; coef[i] = coef_own; end
               PM_COEF_HI: begin pix[i] = pix_packed; coef[i] = op_b[COEF_W +: COEF_W]; end
               PM_COEF_LO: begin pix[i] = pix_packed; coef[i] = op_b[0 +: COEF_W]; end
               PM_BYTE_HI,
               PM_WIDE_HI: begin pix[i] = pix_hi; coef[i] = coef_own; end
               PM_BYTE_LO,
               PM_WIDE_LO: begin pix[i] = pix_lo; coef[i] = coef_own; end
               default:    begin pix[i] = '0; coef[i] = '0; end
            endcase
         end
      end else begin : g_narrow_only
         always_comb begin
            pix[i]  = '0;
            coef[i] = '0;
            unique case (mode)
               PM_BASIC:   begin pix[i] = pix_packed; coef[i] = coef_own; end
               PM_COEF_HI: begin pix[i] = pix_packed; coef[i] = op_b[COEF_W +: COEF_W]; end
               PM_COEF_LO: begin pix[i] = pix_packed; coef[i] = op_b[0 +: COEF_W]; end
               PM_BYTE_HI: begin pix[i] = pix_hi; coef[i] = coef_own; end
               PM_BYTE_LO: begin pix[i] = pix_lo; coef[i] = coef_own; end
               default:    begin pix[i] = '0; coef[i] = '0; end
            endcase
         end
      end
   end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
   parameter int PIX_W = 8
) (
   input  logic [PIX_W-1:0]   pix,
   input  logic [2*PIX_W-1:0] coef,
   output logic [2*PIX_W-1:0] res
);
   localparam int COEF_W = 2 * PIX_W;
   localparam int PROD_W = PIX_W + COEF_W;

   logic signed [PROD_W-1:0] pix_ext, coef_ext, prod;

   // Pixel is unsigned: zero extend. Coefficient is signed: sign extend.
   assign pix_ext  = signed'({{COEF_W{1'b0}}, pix});
   assign coef_ext = signed'({{PIX_W{coef[COEF_W-1]}}, coef});
   assign prod     = pix_ext * coef_ext;

   // R1: middle field plus round bit, wrapping in COEF_W bits
   assign res = prod[PROD_W-1:PIX_W] + COEF_W'(prod[PIX_W-1]);

endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
   import pmul8x16_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int LANES = 4
) (
   input  pm_mode_e                      mode,
   input  logic [LANES-1:0][2*PIX_W-1:0] res,
   output logic [LANES*2*PIX_W-1:0]      word
);
   localparam int COEF_W   = 2 * PIX_W;
   localparam int DATA_W   = LANES * COEF_W;
   localparam int HALF     = LANES / 2;
   localparam int W_STRIDE = 2 * COEF_W;
   localparam int W_OFS    = PIX_W - 1;

   logic [DATA_W-1:0] narrow_word, wide_word;

   for (genvar i = 0; i < LANES; i++) begin : g_narrow
      assign narrow_word[i*COEF_W +: COEF_W] = res[i];
   end

   always_comb begin
      wide_word = '0;
      for (int i = 0; i < HALF; i++) begin
         wide_word[i*W_STRIDE+W_OFS +: COEF_W] = res[i];
      end
   end

   always_comb begin
      unique case (mode)
         PM_WIDE_HI, PM_WIDE_LO: word = wide_word;
         PM_NONE:                word = '0;
         default:                word = narrow_word;
      endcase
   end

endmodule

// File: rtl/pmul8x16_rnd.sv
module pmul8x16_rnd
   import pmul8x16_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int LANES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 mode_sel,
   input  logic [LANES*2*PIX_W-1:0]   op_a,
   input  logic [LANES*2*PIX_W-1:0]   op_b,
   output logic                       out_valid,
   output logic [LANES*2*PIX_W-1:0]   result
);
   localparam int COEF_W = 2 * PIX_W;
   localparam int DATA_W = LANES * COEF_W;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("pmul8x16_rnd: LANES must be even and at least 2");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("pmul8x16_rnd: PIX_W must be at least 2");
   end

   pm_mode_e mode;
   assign mode = pm_mode_e'(mode_sel);

   logic [LANES-1:0][PIX_W-1:0]  lane_pix;
   logic [LANES-1:0][COEF_W-1:0] lane_coef;
   logic [LANES-1:0][COEF_W-1:0] lane_res;
   logic [DATA_W-1:0]            packed_word;

   pmul_opsel #(.PIX_W(PIX_W), .LANES(LANES)) opsel_i (
      .mode (mode),
      .op_a (op_a),
      .op_b (op_b),
      .pix  (lane_pix),
      .coef (lane_coef)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_mul
      pmul_lane #(.PIX_W(PIX_W)) lane_i (
         .pix  (lane_pix[i]),
         .coef (lane_coef[i]),
         .res  (lane_res[i])
      );
   end

   pmul_pack #(.PIX_W(PIX_W), .LANES(LANES)) pack_i (
      .mode (mode),
      .res  (lane_res),
      .word (packed_word)
   );

   // R10, R11, R12: single output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= packed_word;
         end
      end
   end

   a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 3'd7) |=> (result == '0));

   // R7 and R8: bits below the first slot stay clear in the two-lane forms
   a_r7_wide_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode_sel == 3'd5 || mode_sel == 3'd6))
      |=> (result[PIX_W-2:0] == '0));

   a_r3_shared_coef: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 3'd1 && op_a[PIX_W-1:0] == op_a[2*PIX_W-1:PIX_W])
      |=> (result[COEF_W-1:0] == result[2*COEF_W-1:COEF_W]));

   a_r12_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (result == '0 && !out_valid));

endmodule

// File: tb/pmul8x16_rnd_tb.sv
`timescale 1ns/1ps
module pmul8x16_rnd_tb_top;

   localparam real CLK_HALF = 2.0;   // 250 MHz
   localparam int  NVEC     = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        out_valid;
   logic [63:0] result;

   int errors = 0;
   int checks = 0;

   always #(CLK_HALF) clk = ~clk;

   pmul8x16_rnd dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mode_sel  (mode_sel),
      .op_a      (op_a),
      .op_b      (op_b),
      .out_valid (out_valid),
      .result    (result)
   );

   localparam logic [2:0] T_SEL [NVEC] = '{
      3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3,
      3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6 };
   localparam logic [63:0] T_A [NVEC] = '{
      64'hDEAD_BEEF_FF80_0102, 64'h1234_5678_01FF_7F80,
      64'h0000_0000_FF01_7F80, 64'hAAAA_AAAA_0303_0303,
      64'h5555_5555_10FF_2001, 64'h0000_0000_0180_FF02,
      64'hFF01_807F_0A0B_0C0D, 64'h01FF_7F80_FF00_00FF,
      64'hFF01_807F_0A0B_0C0D, 64'h01FF_7F80_FF00_00FF,
      64'hFFFF_FFFF_7F01_FF80, 64'h1234_5678_0203_0405,
      64'hFFFF_FFFF_7F01_FF80, 64'h1234_5678_0203_0405 };
   localparam logic [63:0] T_B [NVEC] = '{
      64'h8000_7FFF_FFFF_0100, 64'hFF00_0080_1234_FFFE,
      64'h0000_0000_8001_0000, 64'hFFFF_FFFF_FF81_0042,
      64'h1111_2222_0000_FFFF, 64'h0000_0000_7FFF_8000,
      64'h8000_7FFF_FFFF_0100, 64'hFFFE_0002_0080_8001,
      64'h8000_7FFF_FFFF_0100, 64'hFFFE_0002_0080_8001,
      64'hABCD_EF01_8000_7FFF, 64'h7777_8888_FFFF_0181,
      64'hABCD_EF01_8000_7FFF, 64'h7777_8888_FFFF_0181 };

   // Lane arithmetic written from R1
   function automatic logic [15:0] ref_lane(logic [7:0] p, logic [15:0] c);
      int          prod;
      logic [31:0] bits;
      prod = int'(p) * int'($signed(c));
      bits = prod;
      return bits[23:8] + {15'b0, bits[7]};
   endfunction

   // Packing written from R2 to R9
   function automatic logic [63:0] ref_word(logic [2:0] s, logic [63:0] a, logic [63:0] b);
      logic [63:0] w;
      w = '0;
      for (int i = 0; i < 4; i++) begin
         case (s)
            3'd0: w[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
            3'd1: w[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
            3'd2: w[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
            3'd3: w[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            3'd4: w[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            3'd5: if (i < 2) w[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            3'd6: if (i < 2) w[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            default: ;
         endcase
      end
      return w;
   endfunction

   function automatic string sel_tag(logic [2:0] s);
      case (s)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         3'd6: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one valid operand pair; return at the negedge after capture
   task automatic apply(logic [2:0] s, logic [63:0] a, logic [63:0] b);
      @(negedge clk);
      mode_sel = s;
      op_a     = a;
      op_b     = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_HALF * 2.0 * 50000.0);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [63:0] held;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 result", result, 64'h0);
      chk("R12 out_valid", {63'b0, out_valid}, 64'h1 & 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table over every variant
      for (int v = 0; v < NVEC; v++) begin
         apply(T_SEL[v], T_A[v], T_B[v]);
         chk(sel_tag(T_SEL[v]), result, ref_word(T_SEL[v], T_A[v], T_B[v]));
      end

      // R1: hand-computed lane corners, select 0 lane 0
      apply(3'd0, 64'h1, 64'h0100);
      chk("R1 exact", result, 64'h1);
      apply(3'd0, 64'h1, 64'h0080);
      chk("R1 round up", result, 64'h1);
      apply(3'd0, 64'h1, 64'hFFFF);
      chk("R1 wrap", result, 64'h0);
      apply(3'd0, 64'h2, 64'hFF00);
      chk("R1 negative", result, 64'hFFFE);

      // R8: double-width placement at bit 7, upper operand fields ignored
      apply(3'd6, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFF_0000_0080);
      chk("R8 placement", result, 64'h80);

      // R9: reserved code with busy operands
      apply(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
      chk("R9 reserved", result, 64'h0);

      // R10: out_valid pulse lasts exactly one cycle
      apply(3'd0, 64'h1, 64'h0100);
      chk("R10 valid high", {63'b0, out_valid}, 64'h1);
      @(negedge clk);
      chk("R10 valid low", {63'b0, out_valid}, 64'h0);

      // R11: operands move with in_valid low, result holds
      held = result;
      mode_sel = 3'd3;
      op_a = 64'hFFFF_FFFF_FFFF_FFFF;
      op_b = 64'h1234_1234_1234_1234;
      repeat (3) @(negedge clk);
      chk("R11 hold", result, held);

      // R12: reset in mid-run clears the register
      apply(3'd0, 64'hFF, 64'h7FFF);
      rst_n = 1'b0;
      #1;
      chk("R12 mid-run result", result, 64'h0);
      chk("R12 mid-run valid", {63'b0, out_valid}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule